// File: doc/BRIEF.md
# Instruction Line Fetch Requester

This block sits beside the fetch stage of a multithreaded core and supplies it with whole instruction-cache lines. Every thread owns one line buffer, tagged with the line-aligned address it holds and a valid bit. When the fetch stage presents a PC for a thread, a tag match on a valid buffer reports a hit. A mismatch starts a line read on a request/response memory port. The response comes back one word per beat and is written into the thread's buffer. The stage reads the buffer through a separate read port.

The memory port may refuse a request. One retry slot, shared by every thread, keeps the refused request and marks the port blocked. The request goes out again when the port raises retry. Each request carries a small tag. A returning line is installed only if its thread is still waiting and the tag matches the one the thread sent. Any other response is thrown away and counted, so a squash never lets stale data into a buffer.

Top module: `ifl_line_requester`

## Requirements
- R1: After reset every thread is in state RUN (code 0), no line is valid, port_blocked_o is 0, both counters are 0 and no request is presented.
- R2: A fetch for a thread in RUN with no stall is a hit when that thread's buffer is valid and its tag equals the PC with the low log2(LINE_WORDS*WORD_W/8) bits cleared. line_hit_o is then 1 in the following cycle and no request is issued.
- R3: A fetch that misses presents one request in the following cycle. The request carries the aligned address, the thread id and a new tag. The thread enters SENT (code 1), its buffer tag takes the aligned address with valid cleared, and issued_cnt_o increments.
- R4: While port_blocked_o is 1, or while irq_pending_i is 1 and fetch_pc_i[1:0] is 00, a fetch neither hits nor issues a request.
- R5: A new request presented while mem_req_ready_i is 0 is kept in the retry slot. port_blocked_o becomes 1 and the owning thread enters WAIT_RETRY (code 2).
- R6: A mem_retry_i pulse with the slot full presents the kept request again in the next cycle. When that request is accepted, the owner enters WAIT_RSP (code 3), the slot empties and port_blocked_o returns to 0. A mem_retry_i pulse with the slot empty only clears port_blocked_o.
- R7: A response is LINE_WORDS consecutive beats. It is accepted only while its thread is in WAIT_RSP and its tag equals the thread's outstanding tag. Otherwise it is dropped: the buffer and state are unchanged and dropped_cnt_o increments once, on its last beat.
- R8: Accepted beat k is written to word k of the thread's buffer and can be read through rd_tid_i/rd_word_i with one cycle of latency. After the last beat the buffer is valid. The thread enters BLOCKED (code 5) if its stall is active and DONE (code 4) otherwise. DONE returns to RUN one cycle later.
- R9: A squash puts the thread in SQUASH (code 6) and forgets its outstanding request. If the thread owns the retry slot, the slot is freed; port_blocked_o is left as it was. One cycle later the thread is in RUN, or in BLOCKED if stalled.
- R10: A stall on a thread in RUN moves it to BLOCKED, where it issues nothing. It returns to RUN in the cycle after the stall drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld_i | input | 1 | Fetch stage presents a PC this cycle |
| fetch_tid_i | input | TID_W | Thread of the fetch |
| fetch_pc_i | input | ADDR_W | Fetch PC |
| irq_pending_i | input | 1 | Interrupt pending, holds off fetch at word-aligned PCs |
| stall_i | input | THREADS | Per-thread stall from later stages |
| squash_i | input | THREADS | Per-thread squash |
| mem_req_valid_o | output | 1 | Line read request presented |
| mem_req_addr_o | output | ADDR_W | Line-aligned request address |
| mem_req_tid_o | output | TID_W | Requesting thread |
| mem_req_tag_o | output | TAG_W | Request tag |
| mem_req_ready_i | input | 1 | Port accepts the presented request |
| mem_retry_i | input | 1 | Port can take a refused request again |
| mem_rsp_valid_i | input | 1 | Response beat valid |
| mem_rsp_tid_i | input | TID_W | Thread of the response |
| mem_rsp_tag_i | input | TAG_W | Tag of the response |
| mem_rsp_data_i | input | WORD_W | Response word |
| rd_tid_i | input | TID_W | Buffer read thread |
| rd_word_i | input | BEAT_W | Buffer read word index |
| rd_data_o | output | WORD_W | Buffer read data, one cycle later |
| line_hit_o | output | 1 | Previous cycle's fetch hit a valid line |
| thread_state_o | output | 3*THREADS | Per-thread state codes, thread t at bits 3t+2:3t |
| port_blocked_o | output | 1 | Port blocked flag |
| issued_cnt_o | output | CNT_W | New requests issued |
| dropped_cnt_o | output | CNT_W | Responses dropped |

## Verification
The bench targets the retry path. A refused request must stay in the slot and come back out with the same address and thread. A design that dropped it would leave the thread in WAIT_RETRY forever. A design that cleared the blocked flag too early would let another thread's hit through. A retry pulse after the owner was squashed must clear the flag without re-presenting anything; a design that kept the slot would send a ghost request. The stale-data cases deliver a line for a squashed request and a line with a wrong tag. A design that installed either would report a hit on the next fetch of that address instead of issuing a fresh read. A fill that completes under stall must land in BLOCKED rather than DONE.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [2:0] {
    TS_RUN    = 3'd0,
    TS_SENT   = 3'd1,
    TS_WRETRY = 3'd2,
    TS_WRSP   = 3'd3,
    TS_DONE   = 3'd4,
    TS_HOLD   = 3'd5,
    TS_FLUSH  = 3'd6
  } tstate_e;
endpackage

// File: rtl/ifl_line_store.sv
module ifl_line_store #(
  parameter int THREADS    = 2,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int AW         = 3
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = THREADS * LINE_WORDS;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ifl_thread_ctl.sv
module ifl_thread_ctl
  import ifl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              squash_i,
  input  logic              stall_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  input  logic              acc_i,
  input  logic              rej_i,
  input  logic              fill_done_i,
  output tstate_e           state_o,
  output logic              line_vld_o,
  output logic [ADDR_W-1:0] line_tag_o,
  output logic [TAG_W-1:0]  out_tag_o
);
  tstate_e state_d;

  always_comb begin
    state_d = state_o;
    if (squash_i) begin
      state_d = TS_FLUSH;
    end else begin
      unique case (state_o)
        TS_RUN:    if (stall_i) state_d = TS_HOLD;
                   else if (issue_i) state_d = TS_SENT;
        TS_SENT:   if (acc_i) state_d = TS_WRSP;
                   else if (rej_i) state_d = TS_WRETRY;
        TS_WRETRY: if (acc_i) state_d = TS_WRSP;
        TS_WRSP:   if (fill_done_i) state_d = stall_i ? TS_HOLD : TS_DONE;
        TS_DONE,
        TS_FLUSH:  state_d = stall_i ? TS_HOLD : TS_RUN;
        TS_HOLD:   if (!stall_i) state_d = TS_RUN;
        default:   state_d = TS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o    <= TS_RUN;
      line_vld_o <= 1'b0;
      line_tag_o <= '0;
      out_tag_o  <= '0;
    end else begin
      state_o <= state_d;
      if (issue_i) begin
        line_tag_o <= issue_addr_i;
        line_vld_o <= 1'b0;
        out_tag_o  <= issue_tag_i;
      end
      if (fill_done_i && !squash_i) line_vld_o <= 1'b1;
    end
  end

  // R3: the buffer stays invalid for as long as its request is outstanding
  assert_wait_no_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == TS_WRSP) |-> !line_vld_o);

  // R8: a buffer only becomes valid at the end of an accepted fill
  assert_valid_after_fill_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(line_vld_o) |-> ($past(state_o) == TS_WRSP));
endmodule

// File: rtl/ifl_port_ctrl.sv
module ifl_port_ctrl #(
  parameter int THREADS = 2,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 3,
  parameter int TID_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_i,
  input  logic [ADDR_W-1:0]  issue_addr_i,
  input  logic [TID_W-1:0]   issue_tid_i,
  input  logic [TAG_W-1:0]   issue_tag_i,
  input  logic [THREADS-1:0] squash_i,
  input  logic               mem_req_ready_i,
  input  logic               mem_retry_i,
  output logic               req_valid_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [TID_W-1:0]   req_tid_o,
  output logic [TAG_W-1:0]   req_tag_o,
  output logic               acc_o,
  output logic               rej_o,
  output logic               blocked_o,
  output logic               slot_vld_o
);
  logic              from_slot_q;
  logic [ADDR_W-1:0] slot_addr_q;
  logic [TID_W-1:0]  slot_tid_q;
  logic [TAG_W-1:0]  slot_tag_q;

  assign acc_o = req_valid_o && mem_req_ready_i;
  assign rej_o = req_valid_o && !mem_req_ready_i && !from_slot_q && !squash_i[req_tid_o];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_o <= 1'b0;
      req_addr_o  <= '0;
      req_tid_o   <= '0;
      req_tag_o   <= '0;
      from_slot_q <= 1'b0;
      slot_vld_o  <= 1'b0;
      slot_addr_q <= '0;
      slot_tid_q  <= '0;
      slot_tag_q  <= '0;
      blocked_o   <= 1'b0;
    end else begin
      req_valid_o <= 1'b0;
      if (acc_o && from_slot_q) begin
        slot_vld_o <= 1'b0;
        blocked_o  <= 1'b0;
      end
      if (rej_o) begin
        slot_vld_o  <= 1'b1;
        slot_addr_q <= req_addr_o;
        slot_tid_q  <= req_tid_o;
        slot_tag_q  <= req_tag_o;
        blocked_o   <= 1'b1;
      end
      if (mem_retry_i) begin
        if (slot_vld_o) begin
          if (!req_valid_o && !squash_i[slot_tid_q]) begin
            req_valid_o <= 1'b1;
            req_addr_o  <= slot_addr_q;
            req_tid_o   <= slot_tid_q;
            req_tag_o   <= slot_tag_q;
            from_slot_q <= 1'b1;
          end
        end else if (!rej_o) begin
          blocked_o <= 1'b0;
        end
      end
      if (slot_vld_o && squash_i[slot_tid_q]) slot_vld_o <= 1'b0;
      if (issue_i) begin
        req_valid_o <= 1'b1;
        req_addr_o  <= issue_addr_i;
        req_tid_o   <= issue_tid_i;
        req_tag_o   <= issue_tag_i;
        from_slot_q <= 1'b0;
      end
    end
  end

  // R5: a kept request always comes with the port marked blocked
  assert_slot_implies_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    slot_vld_o |-> blocked_o);

  // R4: no new request is started while the port is blocked
  assert_no_issue_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !from_slot_q) |-> !$past(blocked_o));
endmodule

// File: rtl/ifl_line_requester.sv
module ifl_line_requester
  import ifl_pkg::*;
#(
  parameter int THREADS    = 2,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 3,
  parameter int CNT_W      = 16,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int BEAT_W    = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_vld_i,
  input  logic [TID_W-1:0]     fetch_tid_i,
  input  logic [ADDR_W-1:0]    fetch_pc_i,
  input  logic                 irq_pending_i,
  input  logic [THREADS-1:0]   stall_i,
  input  logic [THREADS-1:0]   squash_i,
  output logic                 mem_req_valid_o,
  output logic [ADDR_W-1:0]    mem_req_addr_o,
  output logic [TID_W-1:0]     mem_req_tid_o,
  output logic [TAG_W-1:0]     mem_req_tag_o,
  input  logic                 mem_req_ready_i,
  input  logic                 mem_retry_i,
  input  logic                 mem_rsp_valid_i,
  input  logic [TID_W-1:0]     mem_rsp_tid_i,
  input  logic [TAG_W-1:0]     mem_rsp_tag_i,
  input  logic [WORD_W-1:0]    mem_rsp_data_i,
  input  logic [TID_W-1:0]     rd_tid_i,
  input  logic [BEAT_W-1:0]    rd_word_i,
  output logic [WORD_W-1:0]    rd_data_o,
  output logic                 line_hit_o,
  output logic [3*THREADS-1:0] thread_state_o,
  output logic                 port_blocked_o,
  output logic [CNT_W-1:0]     issued_cnt_o,
  output logic [CNT_W-1:0]     dropped_cnt_o
);
  localparam int LINE_BYTES = LINE_WORDS * WORD_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int SAW        = TID_W + BEAT_W;

  tstate_e           st   [THREADS];
  logic              lvld [THREADS];
  logic [ADDR_W-1:0] ltag [THREADS];
  logic [TAG_W-1:0]  otag [THREADS];

  logic [ADDR_W-1:0] fetch_line;
  logic              irq_hold, may_fetch, tag_match, hit_now, issue;
  logic              acc, rej, slot_vld, rsp_ok, last_beat;
  logic [TAG_W-1:0]  tag_q;
  logic [BEAT_W-1:0] beat_q;

  assign fetch_line = {fetch_pc_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign irq_hold   = irq_pending_i && (fetch_pc_i[1:0] == 2'b00);
  assign may_fetch  = fetch_vld_i && (st[fetch_tid_i] == TS_RUN) && !stall_i[fetch_tid_i]
                      && !squash_i[fetch_tid_i] && !port_blocked_o && !irq_hold;
  assign tag_match  = lvld[fetch_tid_i] && (ltag[fetch_tid_i] == fetch_line);
  assign hit_now    = may_fetch && tag_match;
  assign issue      = may_fetch && !tag_match && !mem_req_valid_o && !slot_vld;

  assign last_beat  = (beat_q == BEAT_W'(LINE_WORDS - 1));
  assign rsp_ok     = mem_rsp_valid_i && (st[mem_rsp_tid_i] == TS_WRSP)
                      && (mem_rsp_tag_i == otag[mem_rsp_tid_i]) && !squash_i[mem_rsp_tid_i];

  ifl_port_ctrl #(
    .THREADS(THREADS), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W)
  ) u_port (
    .clk(clk), .rst(rst),
    .issue_i(issue), .issue_addr_i(fetch_line), .issue_tid_i(fetch_tid_i), .issue_tag_i(tag_q),
    .squash_i(squash_i), .mem_req_ready_i(mem_req_ready_i), .mem_retry_i(mem_retry_i),
    .req_valid_o(mem_req_valid_o), .req_addr_o(mem_req_addr_o), .req_tid_o(mem_req_tid_o),
    .req_tag_o(mem_req_tag_o), .acc_o(acc), .rej_o(rej),
    .blocked_o(port_blocked_o), .slot_vld_o(slot_vld)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    ifl_thread_ctl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_thr (
      .clk(clk), .rst(rst),
      .squash_i(squash_i[t]), .stall_i(stall_i[t]),
      .issue_i(issue && (fetch_tid_i == TID_W'(t))),
      .issue_addr_i(fetch_line), .issue_tag_i(tag_q),
      .acc_i(acc && (mem_req_tid_o == TID_W'(t))),
      .rej_i(rej && (mem_req_tid_o == TID_W'(t))),
      .fill_done_i(rsp_ok && last_beat && (mem_rsp_tid_i == TID_W'(t))),
      .state_o(st[t]), .line_vld_o(lvld[t]), .line_tag_o(ltag[t]), .out_tag_o(otag[t])
    );
    assign thread_state_o[3*t +: 3] = st[t];
  end

  ifl_line_store #(
    .THREADS(THREADS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .AW(SAW)
  ) u_store (
    .clk(clk), .we_i(rsp_ok),
    .waddr_i({mem_rsp_tid_i, beat_q}), .wdata_i(mem_rsp_data_i),
    .raddr_i({rd_tid_i, rd_word_i}), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q         <= '0;
      beat_q        <= '0;
      line_hit_o    <= 1'b0;
      issued_cnt_o  <= '0;
      dropped_cnt_o <= '0;
    end else begin
      line_hit_o <= hit_now;
      if (issue) begin
        tag_q        <= tag_q + 1'b1;
        issued_cnt_o <= issued_cnt_o + 1'b1;
      end
      if (mem_rsp_valid_i) begin
        beat_q <= last_beat ? '0 : beat_q + 1'b1;
        if (last_beat && !rsp_ok) dropped_cnt_o <= dropped_cnt_o + 1'b1;
      end
    end
  end

  // R7: the drop counter moves by at most one per cycle
  assert_drop_step_R7: assert property (@(posedge clk) disable iff (rst)
    (dropped_cnt_o == $past(dropped_cnt_o)) || (dropped_cnt_o == $past(dropped_cnt_o) + 1'b1));
endmodule

// File: tb/ifl_line_requester_tb.sv
module ifl_line_requester_tb;
  localparam int THREADS = 2, ADDR_W = 32, WORD_W = 32, LINE_WORDS = 4, TAG_W = 3, CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_vld = 1'b0;
  logic [0:0] fetch_tid = '0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic irq = 1'b0;
  logic [THREADS-1:0] stall = '0, squash = '0;
  logic req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [0:0] req_tid;
  logic [TAG_W-1:0] req_tag;
  logic req_ready = 1'b1, retry = 1'b0;
  logic rsp_valid = 1'b0;
  logic [0:0] rsp_tid = '0;
  logic [TAG_W-1:0] rsp_tag = '0;
  logic [WORD_W-1:0] rsp_data = '0;
  logic [0:0] rd_tid = '0;
  logic [1:0] rd_word = '0;
  logic [WORD_W-1:0] rd_data;
  logic line_hit, blocked;
  logic [3*THREADS-1:0] tstate;
  logic [CNT_W-1:0] issued, dropped;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [TAG_W-1:0] cap_tag;

  always #4 clk = ~clk;

  ifl_line_requester u_dut (
    .clk(clk), .rst(rst), .fetch_vld_i(fetch_vld), .fetch_tid_i(fetch_tid), .fetch_pc_i(fetch_pc),
    .irq_pending_i(irq), .stall_i(stall), .squash_i(squash),
    .mem_req_valid_o(req_valid), .mem_req_addr_o(req_addr), .mem_req_tid_o(req_tid),
    .mem_req_tag_o(req_tag), .mem_req_ready_i(req_ready), .mem_retry_i(retry),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_tid_i(rsp_tid), .mem_rsp_tag_i(rsp_tag),
    .mem_rsp_data_i(rsp_data), .rd_tid_i(rd_tid), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .line_hit_o(line_hit), .thread_state_o(tstate), .port_blocked_o(blocked),
    .issued_cnt_o(issued), .dropped_cnt_o(dropped)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] st(input int t);
    return tstate[3*t +: 3];
  endfunction

  task automatic fetch(input int t, input logic [ADDR_W-1:0] pc);
    fetch_vld = 1'b1; fetch_tid = t[0:0]; fetch_pc = pc;
    step();
    fetch_vld = 1'b0;
  endtask

  task automatic send_line(input int t, input logic [TAG_W-1:0] tg, input logic [WORD_W-1:0] base);
    for (int k = 0; k < LINE_WORDS; k++) begin
      rsp_valid = 1'b1; rsp_tid = t[0:0]; rsp_tag = tg; rsp_data = base + WORD_W'(k);
      step();
    end
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "state0", st(0), 0);
    chk("R1", "state1", st(1), 0);
    chk("R1", "blocked", blocked, 0);
    chk("R1", "req_valid", req_valid, 0);
    chk("R1", "issued", issued, 0);
    chk("R1", "dropped", dropped, 0);
  endtask

  task automatic t_miss_fill();
    fetch(0, 32'h1234);
    chk("R3", "req_valid", req_valid, 1);
    chk("R3", "req_addr", req_addr, 32'h1230);
    chk("R3", "req_tid", req_tid, 0);
    chk("R3", "state SENT", st(0), 1);
    chk("R3", "issued", issued, 1);
    cap_tag = req_tag;
    step();
    chk("R6", "state WAIT_RSP", st(0), 3);
    send_line(0, cap_tag, 32'hA000);
    chk("R8", "state DONE", st(0), 4);
    step();
    chk("R8", "state RUN", st(0), 0);
    for (int k = 0; k < LINE_WORDS; k++) begin
      rd_tid = 0; rd_word = k[1:0];
      step();
      chk("R8", "rd_data", rd_data, 32'hA000 + k);
    end
  endtask

  task automatic t_hit();
    fetch(0, 32'h1238);
    chk("R2", "line_hit", line_hit, 1);
    chk("R2", "no request", req_valid, 0);
    chk("R2", "issued unchanged", issued, 1);
  endtask

  task automatic t_reject_retry();
    req_ready = 1'b0;
    fetch(1, 32'h4000);
    chk("R3", "req_valid t1", req_valid, 1);
    step();
    chk("R5", "state WAIT_RETRY", st(1), 2);
    chk("R5", "blocked", blocked, 1);
    chk("R5", "no request", req_valid, 0);
    fetch(0, 32'h1234);
    chk("R4", "hit refused while blocked", line_hit, 0);
    req_ready = 1'b1; retry = 1'b1;
    step();
    retry = 1'b0;
    chk("R6", "resend valid", req_valid, 1);
    chk("R6", "resend addr", req_addr, 32'h4000);
    chk("R6", "resend tid", req_tid, 1);
    cap_tag = req_tag;
    step();
    chk("R6", "state WAIT_RSP", st(1), 3);
    chk("R6", "blocked cleared", blocked, 0);
    send_line(1, cap_tag, 32'hB000);
    step();
    chk("R8", "t1 back to RUN", st(1), 0);
  endtask

  task automatic t_squash_slot();
    req_ready = 1'b0;
    fetch(1, 32'h5000);
    step();
    req_ready = 1'b1;
    chk("R5", "state WAIT_RETRY", st(1), 2);
    squash[1] = 1'b1;
    step();
    squash[1] = 1'b0;
    chk("R9", "state SQUASH", st(1), 6);
    chk("R9", "blocked kept", blocked, 1);
    step();
    chk("R9", "state RUN", st(1), 0);
    retry = 1'b1;
    step();
    retry = 1'b0;
    chk("R6", "blocked cleared by empty retry", blocked, 0);
    chk("R9", "freed slot not resent", req_valid, 0);
  endtask

  task automatic t_stale();
    fetch(0, 32'h6000);
    cap_tag = req_tag;
    step();
    chk("R3", "state WAIT_RSP", st(0), 3);
    squash[0] = 1'b1;
    step();
    squash[0] = 1'b0;
    step();
    send_line(0, cap_tag, 32'hC000);
    chk("R7", "squashed response dropped", dropped, 1);
    chk("R7", "state unchanged", st(0), 0);
    fetch(0, 32'h6000);
    chk("R7", "stale line not installed", req_valid, 1);
    cap_tag = req_tag;
    step();
    send_line(0, cap_tag + 1'b1, 32'hD000);
    chk("R7", "wrong tag dropped", dropped, 2);
    chk("R7", "still WAIT_RSP", st(0), 3);
    stall[0] = 1'b1;
    send_line(0, cap_tag, 32'hE000);
    chk("R8", "fill under stall BLOCKED", st(0), 5);
    stall[0] = 1'b0;
    step();
    chk("R10", "unstall RUN", st(0), 0);
    fetch(0, 32'h6004);
    chk("R8", "filled line hits", line_hit, 1);
    rd_tid = 0; rd_word = 2'd1;
    step();
    chk("R7", "buffer holds accepted data", rd_data, 32'hE001);
  endtask

  task automatic t_stall_irq();
    stall[1] = 1'b1;
    step();
    chk("R10", "stall BLOCKED", st(1), 5);
    fetch(1, 32'h7000);
    chk("R10", "no issue while blocked", req_valid, 0);
    stall[1] = 1'b0;
    step();
    chk("R10", "back to RUN", st(1), 0);
    irq = 1'b1;
    fetch(0, 32'h6000);
    chk("R4", "irq refuses aligned pc", line_hit, 0);
    chk("R4", "irq no request", req_valid, 0);
    fetch(0, 32'h6002);
    chk("R4", "irq allows pc[1:0]!=0", line_hit, 1);
    irq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_fill();
    t_hit();
    t_reject_retry();
    t_squash_slot();
    t_stale();
    t_stall_irq();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule